// File: doc/BRIEF.md
# Switching-Event Bus Arbiter and Packetizer

This block collects switching-state changes from nine H-bridge power modules and sends them, one at a time, over a single shared bus back out to the modules. Each module drives a 2-bit switching state and a one-cycle change strobe. The strobe latches a pending request for that module. A selector chooses one pending module, and a small bus sequencer sends a packet for it. The packet holds the module's binary address, the module's current 2-bit state and a trigger pulse that tells the addressed module to latch the packet.

The sequencer clears the served module's request when it takes the packet, which is the moment it captures the state. A change that arrives later, including one in that same cycle, sets the request again, so no event is lost. Fixed lowest-index priority is the default. A parameter switches to a rotating order that starts just after the module served last.

Top module: `switch_event_packetizer`

## Requirements
- R1: After reset, `bus_busy` and `bus_trig` are low and no request is pending, so no packet appears until a new change strobe arrives. A reset also discards requests that were pending before it.
- R2: A change strobe on module i latches a pending request. Each latched request produces exactly one packet.
- R3: With `ARB_RR`=0, the lowest pending index is served first, so modules that become pending together go out in ascending address order.
- R4: `bus_addr` carries the served module index in plain binary, from 0 to 8. `bus_state` carries that module's 2-bit state, taken from bits [2i+1:2i] of `mod_state`.
- R5: The state is sampled when the packet is issued. If a module changes several times before it is served, one packet goes out and it carries the latest state.
- R6: Every packet begins with exactly one setup cycle. In that cycle `bus_busy` is high, `bus_trig` is low and the fields are already valid.
- R7: `bus_trig` stays high for exactly `TRIG_CYC` consecutive cycles (3 by default). `bus_addr` and `bus_state` hold their values from the setup cycle to the end of the trigger.
- R8: A request is cleared when its packet is issued. A change strobe for the same module in that same cycle keeps the request set, and a second packet follows.
- R9: While no request is pending, `bus_trig` and `bus_busy` stay low. `bus_busy` drops for at least one cycle between consecutive packets.
- R10: With `ARB_RR`=1, the search starts at the index after the module served last, wrapping from 8 to 0. After reset the search starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_state | input | 18 | Packed 2-bit switching states, module i at bits [2i+1:2i] |
| mod_chg | input | 9 | One-cycle change strobe per module |
| bus_addr | output | 4 | Binary address of the module being served |
| bus_state | output | 2 | Switching state sent to the addressed module |
| bus_trig | output | 1 | Latch strobe for the addressed module |
| bus_busy | output | 1 | High while a packet is in setup or trigger |

## Verification
The bench puts a change on a module whose request is being cleared in that same cycle. A design that clears at the wrong time would send one packet instead of two. It also changes a module twice while another module holds the bus. A design that snapshots the state at the strobe would send a stale value, and one that queues every strobe would send extra packets. A late low-index request during a busy burst separates fixed priority from rotating priority. Swapping the two orders changes the packet sequence. Trigger width, the setup cycle and the idle gap between packets are measured directly, so an off-by-one count or a missing setup cycle shows up as a wrong run length or a lost busy rise.

// File: rtl/swev_pkg.sv
package swev_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_TRIG  = 2'd2
  } bus_phase_t;

  // Rotating search over up to 16 request lines. It scans from 'start'
  // upward, wraps at 'n' and returns the first set index.
  function automatic logic [3:0] rot_pick(input logic [15:0] req,
                                          input logic [3:0]  start,
                                          input logic [4:0]  n);
    logic [4:0] pos;
    logic       hit;
    rot_pick = 4'd0;
    hit      = 1'b0;
    for (int k = 0; k < 16; k++) begin
      pos = 5'(start) + 5'(k);
      if (pos >= n) pos = pos - n;
      if (!hit && (5'(k) < n) && req[pos[3:0]]) begin
        rot_pick = pos[3:0];
        hit      = 1'b1;
      end
    end
  endfunction

endpackage

// File: rtl/swev_req_bank.sv
module swev_req_bank #(
  parameter int N_MOD = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MOD-1:0] chg,
  input  logic [N_MOD-1:0] clr,
  output logic [N_MOD-1:0] pend
);
  // A new event wins over a clear in the same cycle.
  for (genvar i = 0; i < N_MOD; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= (pend[i] & ~clr[i]) | chg[i];
    end
  end
endmodule

// File: rtl/swev_pick.sv
module swev_pick
  import swev_pkg::*;
#(
  parameter int N_MOD  = 9,
  parameter int ADDR_W = 4,
  parameter bit ARB_RR = 1'b0
) (
  input  logic [N_MOD-1:0]  req,
  input  logic [ADDR_W-1:0] last,
  output logic              any,
  output logic [ADDR_W-1:0] idx
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(N_MOD - 1);

  logic [3:0] start;

  if (ARB_RR) begin : g_rr
    assign start = (last == LAST_IDX) ? 4'd0 : 4'(last + 1'b1);
  end else begin : g_fixed
    assign start = 4'd0;
  end

  assign any = |req;
  assign idx = ADDR_W'(rot_pick(16'(req), start, 5'(N_MOD)));
endmodule

// File: rtl/swev_bus_seq.sv
module swev_bus_seq
  import swev_pkg::*;
#(
  parameter int N_MOD    = 9,
  parameter int ADDR_W   = 4,
  parameter int ST_W     = 2,
  parameter int TRIG_CYC = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  any,
  input  logic [ADDR_W-1:0]     idx,
  input  logic [N_MOD*ST_W-1:0] states,
  output logic [ADDR_W-1:0]     addr,
  output logic [ST_W-1:0]       state,
  output logic                  trig,
  output logic                  busy,
  output logic                  issue,
  output logic [N_MOD-1:0]      clr,
  output logic [ADDR_W-1:0]     last
);
  localparam int CW = $clog2(TRIG_CYC + 1);

  bus_phase_t    ph;
  logic [CW-1:0] cnt;

  function automatic logic [ST_W-1:0] sel_state(input logic [N_MOD*ST_W-1:0] s,
                                                input logic [ADDR_W-1:0]     a);
    sel_state = '0;
    for (int m = 0; m < N_MOD; m++)
      if (a == ADDR_W'(m)) sel_state = s[m*ST_W +: ST_W];
  endfunction

  assign issue = (ph == PH_IDLE) && any;
  assign trig  = (ph == PH_TRIG);
  assign busy  = (ph != PH_IDLE);

  for (genvar i = 0; i < N_MOD; i++) begin : g_clr
    assign clr[i] = issue && (idx == ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      addr  <= '0;
      state <= '0;
      last  <= ADDR_W'(N_MOD - 1);
    end else begin
      unique case (ph)
        PH_IDLE: if (any) begin
          ph    <= PH_SETUP;
          addr  <= idx;
          state <= sel_state(states, idx);
          last  <= idx;
        end
        PH_SETUP: begin
          ph  <= PH_TRIG;
          cnt <= CW'(1);
        end
        PH_TRIG: begin
          if (cnt == CW'(TRIG_CYC)) ph <= PH_IDLE;
          else                      cnt <= cnt + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/switch_event_packetizer.sv
module switch_event_packetizer #(
  parameter int N_MOD    = 9,
  parameter int ADDR_W   = 4,
  parameter int ST_W     = 2,
  parameter int TRIG_CYC = 3,
  parameter bit ARB_RR   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_MOD*ST_W-1:0] mod_state,
  input  logic [N_MOD-1:0]      mod_chg,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [ST_W-1:0]       bus_state,
  output logic                  bus_trig,
  output logic                  bus_busy
);
  // These named wires are kept visible so the bound checker can see them.
  logic [N_MOD-1:0]  pend_q;
  logic [N_MOD-1:0]  clr_vec;
  logic              any_w;
  logic              issue_w;
  logic [ADDR_W-1:0] pick_idx;
  logic [ADDR_W-1:0] last_idx;

  swev_req_bank #(.N_MOD(N_MOD)) u_bank (
    .clk (clk),
    .rst_n (rst_n),
    .chg (mod_chg),
    .clr (clr_vec),
    .pend (pend_q)
  );

  swev_pick #(.N_MOD(N_MOD), .ADDR_W(ADDR_W), .ARB_RR(ARB_RR)) u_pick (
    .req  (pend_q),
    .last (last_idx),
    .any  (any_w),
    .idx  (pick_idx)
  );

  swev_bus_seq #(.N_MOD(N_MOD), .ADDR_W(ADDR_W), .ST_W(ST_W), .TRIG_CYC(TRIG_CYC)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .any    (any_w),
    .idx    (pick_idx),
    .states (mod_state),
    .addr   (bus_addr),
    .state  (bus_state),
    .trig   (bus_trig),
    .busy   (bus_busy),
    .issue  (issue_w),
    .clr    (clr_vec),
    .last   (last_idx)
  );
endmodule

// File: rtl/swev_bus_chk.sv
module swev_bus_chk #(
  parameter int N_MOD    = 9,
  parameter int ADDR_W   = 4,
  parameter int ST_W     = 2,
  parameter int TRIG_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_MOD-1:0]  chg,
  input logic [N_MOD-1:0]  pend,
  input logic [N_MOD-1:0]  clr,
  input logic              issue,
  input logic [ADDR_W-1:0] addr,
  input logic [ST_W-1:0]   state,
  input logic              trig,
  input logic              busy
);
  logic [15:0] trig_run;
  always_ff @(posedge clk) begin
    if (!rst_n)    trig_run <= '0;
    else if (trig) trig_run <= trig_run + 1'b1;
    else           trig_run <= '0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !busy && !trig && pend == '0);
  p_event_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> ((pend & $past(chg)) == $past(chg)));
  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (addr < ADDR_W'(N_MOD)));
  p_setup_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $past(busy) && !$past(trig));
  p_trig_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig) |-> (trig_run == 16'(TRIG_CYC)));
  p_trig_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (trig_run < 16'(TRIG_CYC)));
  p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr) && $stable(state)));
  p_single_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ($countones(clr) == 1));
  p_clear_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(clr));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && !busy) |=> !trig && !busy);
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig) |-> !busy);
endmodule

bind switch_event_packetizer swev_bus_chk #(
  .N_MOD(N_MOD), .ADDR_W(ADDR_W), .ST_W(ST_W), .TRIG_CYC(TRIG_CYC)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .chg   (mod_chg),
  .pend  (pend_q),
  .clr   (clr_vec),
  .issue (issue_w),
  .addr  (bus_addr),
  .state (bus_state),
  .trig  (bus_trig),
  .busy  (bus_busy)
);

// File: tb/switch_event_packetizer_tb.sv
module switch_event_packetizer_tb_top;
  localparam int N   = 9;
  localparam int TC  = 3;
  localparam int WAITC = 12 * (TC + 2) + 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [17:0]  mod_state = '0;
  logic [8:0]   mod_chg = '0;
  logic [3:0]   bus_addr, rr_addr;
  logic [1:0]   bus_state, rr_state;
  logic         bus_trig, rr_trig, bus_busy, rr_busy;

  always #10 clk = ~clk;

  switch_event_packetizer #(.TRIG_CYC(TC)) dut_i (
    .clk(clk), .rst_n(rst_n), .mod_state(mod_state), .mod_chg(mod_chg),
    .bus_addr(bus_addr), .bus_state(bus_state), .bus_trig(bus_trig), .bus_busy(bus_busy));

  switch_event_packetizer #(.TRIG_CYC(TC), .ARB_RR(1'b1)) dut_rr (
    .clk(clk), .rst_n(rst_n), .mod_state(mod_state), .mod_chg(mod_chg),
    .bus_addr(rr_addr), .bus_state(rr_state), .bus_trig(rr_trig), .bus_busy(rr_busy));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Packet monitor
  logic [3:0] cap_a [0:31];
  logic [1:0] cap_s [0:31];
  logic [3:0] rrc_a [0:31];
  int cap_n = 0, rr_n = 0, rises = 0;
  logic tprev = 0, bprev = 0, rtprev = 0;
  int run = 0;
  logic [3:0] setup_a;
  logic [1:0] setup_s;

  always @(negedge clk) begin
    if (!rst_n) begin
      tprev = 0; bprev = 0; rtprev = 0; run = 0;
    end else begin
      if (bus_busy && !bprev) begin
        rises++;
        setup_a = bus_addr;
        setup_s = bus_state;
        chk(!bus_trig, "R6 trig low in setup", int'(bus_trig), 0);
      end
      if (bus_trig && !tprev) begin
        chk(bprev, "R6 setup cycle before trig", int'(bprev), 1);
        chk(bus_addr == setup_a && bus_state == setup_s, "R7 fields stable from setup",
            int'(bus_addr), int'(setup_a));
        if (cap_n < 32) begin cap_a[cap_n] = bus_addr; cap_s[cap_n] = bus_state; end
        cap_n++;
      end
      if (bus_trig) begin
        run++;
        if (bus_addr != setup_a || bus_state != setup_s)
          chk(1'b0, "R7 fields stable during trig", int'(bus_addr), int'(setup_a));
      end else if (tprev) begin
        chk(run == TC, "R7 trig width", run, TC);
        run = 0;
      end
      if (rr_trig && !rtprev) begin
        if (rr_n < 32) rrc_a[rr_n] = rr_addr;
        rr_n++;
      end
      tprev = bus_trig; bprev = bus_busy; rtprev = rr_trig;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic clear_cap();
    cap_n = 0; rr_n = 0; rises = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; mod_chg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_cap();
  endtask

  // {change mask, packed states}
  localparam logic [26:0] VEC [0:5] = '{
    {9'h001, 18'h00003},
    {9'h100, 18'h20000},
    {9'h1FF, 18'h2D8B1},
    {9'h0AA, 18'h3C3C3},
    {9'h111, 18'h15A96},
    {9'h0F0, 18'h3FFFF}
  };

  initial begin
    // R1: reset state, requests pending before reset are dropped
    @(negedge clk);
    mod_chg = 9'h1FF;
    @(negedge clk);
    mod_chg = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_busy && !bus_trig, "R1 outputs low in reset", int'(bus_busy), 0);
    rst_n = 1'b1;
    clear_cap();
    repeat (20) @(negedge clk);
    chk(cap_n == 0, "R1 no packet after reset", cap_n, 0);
    chk(!bus_busy && !bus_trig, "R9 idle outputs", int'(bus_trig), 0);

    // Vector table: R2, R3, R4
    for (int v = 0; v < 6; v++) begin
      logic [8:0]  m;
      logic [17:0] s;
      int          e;
      m = VEC[v][26:18];
      s = VEC[v][17:0];
      clear_cap();
      mod_state = s;
      mod_chg   = m;
      @(negedge clk);
      mod_chg = '0;
      repeat (WAITC) @(negedge clk);
      chk(cap_n == $countones(m), "R2 one packet per request", cap_n, $countones(m));
      chk(rises == $countones(m), "R9 busy gap between packets", rises, $countones(m));
      e = 0;
      for (int i = 0; i < N; i++) begin
        if (m[i]) begin
          chk(cap_a[e] == 4'(i), "R3 ascending order", int'(cap_a[e]), i);
          chk(cap_s[e] == s[2*i +: 2], "R4 state field", int'(cap_s[e]), int'(s[2*i +: 2]));
          e++;
        end
      end
      chk(!bus_busy && !bus_trig, "R9 idle after burst", int'(bus_busy), 0);
    end

    // R5: latest state is sent once
    do_reset();
    mod_state = 18'h00002 | (18'd1 << 10);
    mod_chg = 9'h021;
    @(negedge clk);
    mod_state[11:10] = 2'd2; mod_chg = 9'h020;
    @(negedge clk);
    mod_state[11:10] = 2'd3; mod_chg = 9'h020;
    @(negedge clk);
    mod_chg = '0;
    repeat (WAITC) @(negedge clk);
    chk(cap_n == 2, "R5 packet count", cap_n, 2);
    chk(cap_a[1] == 4'd5, "R5 second addr", int'(cap_a[1]), 5);
    chk(cap_s[1] == 2'd3, "R5 latest state", int'(cap_s[1]), 3);

    // R8: edge in the clearing cycle keeps the request
    do_reset();
    mod_state = 18'd1 << 6;
    mod_chg = 9'h008;
    @(negedge clk);
    mod_state[7:6] = 2'd2;
    mod_chg = 9'h008;
    @(negedge clk);
    mod_chg = '0;
    repeat (WAITC) @(negedge clk);
    chk(cap_n == 2, "R8 re-armed request", cap_n, 2);
    chk(cap_a[0] == 4'd3 && cap_a[1] == 4'd3, "R8 both to module 3", int'(cap_a[1]), 3);
    chk(cap_s[1] == 2'd2, "R8 state", int'(cap_s[1]), 2);

    // R10: late low-index request, fixed vs rotating
    do_reset();
    mod_state = '0;
    mod_chg = 9'h086;
    @(negedge clk);
    mod_chg = '0;
    @(negedge clk);
    mod_chg = 9'h001;
    @(negedge clk);
    mod_chg = '0;
    repeat (WAITC) @(negedge clk);
    chk(cap_n == 4 && rr_n == 4, "R10 packet counts", cap_n, 4);
    chk(cap_a[0] == 1 && cap_a[1] == 0 && cap_a[2] == 2 && cap_a[3] == 7,
        "R3 fixed order 1,0,2,7", int'(cap_a[1]), 0);
    chk(rrc_a[0] == 1 && rrc_a[1] == 2 && rrc_a[2] == 7 && rrc_a[3] == 0,
        "R10 rotating order 1,2,7,0", int'(rrc_a[1]), 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule